// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block joins two eight-line interrupt cores into one sixteen-source controller. The master core takes sources 0 to 7. The slave core takes sources 8 to 15. A source is recorded on the rising edge of its input. Each core then selects a winner by fixed priority, where the lowest line number wins. A core offers its winner only when that winner ranks above every line the core already has in service.

The slave core does not reach the processor directly. While the slave has a qualifying winner, a short pulse is sent into master line 2. The master's own edge detector records that pulse like any other source. The processor sees a single interrupt output, which is high whenever the master has a winner.

When the processor strobes acknowledge, the block does three things:
- It latches a 4-bit request number.
- It moves the winning request into service in the master core, and also in the slave core when the request came through the cascade line.
- It forms an 8-bit vector from a configured base value.

The processor later ends service by sending an end-of-interrupt strobe that carries the request number.

Top module: `pic_cascade_ack`

## Requirements
- R1: While reset is held, `int_o` is 0, `num_o` is 0 and `vector_o` is 0.
- R2: A rising edge on `irq_i[n]` for n in {0,1,3,4,5,6,7} is recorded on master line n. `int_o` rises after the first clock edge that samples the high level. A level that stays high after its request has been served raises no new request.
- R3: Within a core, the lowest pending line wins. A line is offered only when its number is lower than every line in service in that core. Lines blocked this way wait, and are offered once the blocking lines leave service.
- R4: A slave winner drives master line 2 with a pulse that is high for one cycle and then low. Measured from the edge that records a slave source, `int_o` rises after the second following edge. While the slave winner persists, the pulse repeats every other cycle.
- R5: At an acknowledge edge, `num_o` takes one of two values. If the master winner is line 2, it becomes 8 plus the slave winner line. Otherwise it becomes the master winner line. `num_o` holds this value until the next acknowledge.
- R6: From the cycle after an acknowledge, `vector_o` has bits [7:3] taken from the slave base when `num_o` >= 8, and from the master base otherwise. Bits [2:0] equal `num_o[2:0]`. Bits [2:0] of both base inputs are ignored.
- R7: An acknowledge of a number n below 8 clears pending line n and sets in-service line n in the master. An acknowledge of n >= 8 does the same for slave line n-8 and for master line 2.
- R8: An acknowledge with no master winner returns number 7 and the master base plus 7, and changes no core state. When master line 2 wins but the slave has no winner, the acknowledge returns number 15 and the slave base plus 7. In that case only master line 2 is moved into service.
- R9: An end-of-interrupt with number n below 8 clears master in-service line n. With n >= 8, it clears slave in-service line n-8 and master in-service line 2.
- R10: `irq_i[2]` has no effect. Master line 2 is fed only by the cascade pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Interrupt sources. Bit 3 selects the core, bits [2:0] the line |
| master_base_i | input | 8 | Vector base for the master core. Bits [2:0] are ignored |
| slave_base_i | input | 8 | Vector base for the slave core. Bits [2:0] are ignored |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| eoi_i | input | 1 | End-of-interrupt strobe, one cycle |
| eoi_num_i | input | 4 | Request number being ended |
| int_o | output | 1 | Interrupt request to the processor |
| num_o | output | 4 | Request number latched at the last acknowledge |
| vector_o | output | 8 | Vector formed at the last acknowledge |

## Verification
The bench first targets the cascade path in flight. A slave source acknowledged while a cascade pulse is still travelling leaves a stale pending bit on master line 2. After the end-of-interrupt, that bit must surface as number 15 with the slave base plus 7. A design that skipped this spurious case would report a stale slave line, or would hang with `int_o` high.

It nests a higher-priority source over one already in service, and checks that a lower one stays blocked until both are ended. A comparator that was off by one, or a design that ignored the in-service set, would let line 6 through too early.

Further cases cover:
- A master line that beats the cascade line.
- An acknowledge with nothing pending.
- Bases with their low bits set, which must not leak into the vector.
- The unused input 2, which must never raise `int_o`.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;

  // Index of the lowest set bit among the first n bits, or n when none is set.
  function automatic int lowest_set(input logic [31:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      if (bits[i]) return i;
    end
    return n;
  endfunction

  // Clear the low lw bits of the base, then place the line number in them.
  function automatic logic [31:0] make_vector(input logic [31:0] base,
                                              input logic [31:0] line,
                                              input int lw);
    logic [31:0] upper;
    upper = (base >> lw) << lw;
    return upper | line;
  endfunction

endpackage

// File: rtl/pic_core.sv
module pic_core #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic             ack_i,
  input  logic [LW-1:0]    ack_line_i,
  input  logic             eoi_i,
  input  logic [LW-1:0]    eoi_line_i,
  output logic             win_valid_o,
  output logic [LW-1:0]    win_line_o,
  output logic [LINES-1:0] irr_o
);
  import pic_cascade_pkg::*;

  logic [LINES-1:0] last_q, irr_q, isr_q;
  logic [LINES-1:0] rise, ack_mask, eoi_mask;
  int               irr_pri, isr_pri;

  // Edge detection and one-hot decode of the acknowledge and EOI lines.
  always_comb begin
    rise     = req_i & ~last_q;
    ack_mask = ack_i ? (LINES'(1) << ack_line_i) : '0;
    eoi_mask = eoi_i ? (LINES'(1) << eoi_line_i) : '0;
  end

  // Winner selection: the lowest pending line must rank above every line in service.
  always_comb begin
    irr_pri     = lowest_set(32'(irr_q), LINES);
    isr_pri     = lowest_set(32'(isr_q), LINES);
    win_valid_o = irr_pri < isr_pri;
    win_line_o  = irr_pri[LW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
    end else begin
      last_q <= req_i;
      irr_q  <= (irr_q & ~ack_mask) | rise;
      isr_q  <= (isr_q & ~eoi_mask) | ack_mask;
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/pic_cascade_link.sv
module pic_cascade_link #(
  parameter int LINES = 8,
  parameter int CASC  = 2,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_valid_i,
  input  logic [LW-1:0] slave_line_i,
  input  logic          master_valid_i,
  input  logic [LW-1:0] master_line_i,
  output logic          casc_o,
  output logic          via_slave_o,
  output logic [LW:0]   req_num_o
);
  localparam logic [LW-1:0] SPUR = LW'(LINES - 1);

  logic casc_q;

  // Build the global request number from the two winners.
  function automatic logic [LW:0] compose(input logic mv, input logic [LW-1:0] ml,
                                          input logic sv, input logic [LW-1:0] sl);
    if (!mv)                 return {1'b0, SPUR};
    if (ml == LW'(CASC))     return {1'b1, (sv ? sl : SPUR)};
    return {1'b0, ml};
  endfunction

  // High for one cycle, then low, for as long as the slave has a winner.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) casc_q <= 1'b0;
    else        casc_q <= slave_valid_i & ~casc_q;
  end

  assign casc_o      = casc_q;
  assign via_slave_o = master_valid_i && (master_line_i == LW'(CASC));
  assign req_num_o   = compose(master_valid_i, master_line_i, slave_valid_i, slave_line_i);
endmodule

// File: rtl/pic_vector_latch.sv
module pic_vector_latch #(
  parameter int LINES = 8,
  parameter int VW    = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [LW:0]   num_i,
  input  logic [VW-1:0] master_base_i,
  input  logic [VW-1:0] slave_base_i,
  output logic [LW:0]   num_o,
  output logic [VW-1:0] vector_o
);
  import pic_cascade_pkg::*;

  logic [LW:0]   num_q;
  logic [VW-1:0] vec_q;
  logic [31:0]   vec_next;

  always_comb begin
    vec_next = make_vector(32'(num_i[LW] ? slave_base_i : master_base_i),
                           32'(num_i[LW-1:0]), LW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
      vec_q <= '0;
    end else if (take_i) begin
      num_q <= num_i;
      vec_q <= vec_next[VW-1:0];
    end
  end

  assign num_o    = num_q;
  assign vector_o = vec_q;
endmodule

// File: rtl/pic_cascade_ack.sv
module pic_cascade_ack #(
  parameter int LINES     = 8,
  parameter int CASC_LINE = 2,
  parameter int VEC_W     = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*LINES-1:0] irq_i,
  input  logic [VEC_W-1:0]   master_base_i,
  input  logic [VEC_W-1:0]   slave_base_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  input  logic [LW:0]        eoi_num_i,
  output logic               int_o,
  output logic [LW:0]        num_o,
  output logic [VEC_W-1:0]   vector_o
);
  logic [LINES-1:0] master_req, master_irr, slave_irr;
  logic             master_valid, slave_valid, via_slave, casc_q;
  logic [LW-1:0]    master_line, slave_line;
  logic [LW:0]      req_num;
  logic             master_ack, slave_ack, master_eoi, slave_eoi;
  logic [LW-1:0]    master_ack_line, slave_ack_line, master_eoi_line;

  // Master inputs: every global source below LINES, except the cascade line.
  for (genvar g = 0; g < LINES; g++) begin : g_mreq
    if (g == CASC_LINE) begin : g_casc
      assign master_req[g] = casc_q;
    end else begin : g_src
      assign master_req[g] = irq_i[g];
    end
  end

  // Acknowledge routing.
  assign master_ack      = ack_i & master_valid;
  assign master_ack_line = master_line;
  assign slave_ack       = ack_i & via_slave & slave_valid;
  assign slave_ack_line  = slave_line;

  // End-of-interrupt routing.
  assign slave_eoi       = eoi_i & eoi_num_i[LW];
  assign master_eoi      = eoi_i;
  assign master_eoi_line = eoi_num_i[LW] ? LW'(CASC_LINE) : eoi_num_i[LW-1:0];

  pic_core #(.LINES(LINES)) u_master (
    .clk(clk), .rst_n(rst_n), .req_i(master_req),
    .ack_i(master_ack), .ack_line_i(master_ack_line),
    .eoi_i(master_eoi), .eoi_line_i(master_eoi_line),
    .win_valid_o(master_valid), .win_line_o(master_line), .irr_o(master_irr)
  );

  pic_core #(.LINES(LINES)) u_slave (
    .clk(clk), .rst_n(rst_n), .req_i(irq_i[2*LINES-1:LINES]),
    .ack_i(slave_ack), .ack_line_i(slave_ack_line),
    .eoi_i(slave_eoi), .eoi_line_i(eoi_num_i[LW-1:0]),
    .win_valid_o(slave_valid), .win_line_o(slave_line), .irr_o(slave_irr)
  );

  pic_cascade_link #(.LINES(LINES), .CASC(CASC_LINE)) u_link (
    .clk(clk), .rst_n(rst_n),
    .slave_valid_i(slave_valid), .slave_line_i(slave_line),
    .master_valid_i(master_valid), .master_line_i(master_line),
    .casc_o(casc_q), .via_slave_o(via_slave), .req_num_o(req_num)
  );

  pic_vector_latch #(.LINES(LINES), .VW(VEC_W)) u_vec (
    .clk(clk), .rst_n(rst_n), .take_i(ack_i), .num_i(req_num),
    .master_base_i(master_base_i), .slave_base_i(slave_base_i),
    .num_o(num_o), .vector_o(vector_o)
  );

  assign int_o = master_valid;
endmodule

// File: rtl/pic_cascade_ack_chk.sv
module pic_cascade_ack_chk #(
  parameter int LINES = 8,
  parameter int CASC  = 2,
  parameter int VW    = 8,
  localparam int LW = $clog2(LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*LINES-1:0] irq_i,
  input logic               ack_i,
  input logic               int_o,
  input logic [LW:0]        num_o,
  input logic [VW-1:0]      vector_o,
  input logic [VW-1:0]      master_base_i,
  input logic [VW-1:0]      slave_base_i,
  input logic               casc_q,
  input logic [LINES-1:0]   master_irr,
  input logic [LINES-1:0]   slave_irr,
  input logic               master_ack,
  input logic [LW-1:0]      master_ack_line,
  input logic               slave_ack,
  input logic [LW-1:0]      slave_ack_line
);
  AST_INT_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (|master_irr)); // R2

  AST_CASC_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    casc_q |=> !casc_q); // R4

  AST_CASC_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_irr[CASC]) |-> $past(casc_q)); // R4

  AST_NUM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> $stable(num_o)); // R5

  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vector_o[VW-1:LW] == (num_o[LW] ? $past(slave_base_i[VW-1:LW])
                                              : $past(master_base_i[VW-1:LW]))); // R6

  AST_VEC_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vector_o[LW-1:0] == num_o[LW-1:0]); // R6

  AST_SLAVE_ACK_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    slave_ack |-> (master_ack && master_ack_line == LW'(CASC) && slave_irr[slave_ack_line])); // R7

  AST_SPURIOUS_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o) |-> (!master_ack && !slave_ack)); // R8

  AST_IGNORED_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i[CASC] && !$past(casc_q)) |-> !$rose(master_irr[CASC])); // R10
endmodule

bind pic_cascade_ack pic_cascade_ack_chk #(.LINES(LINES), .CASC(CASC_LINE), .VW(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .ack_i(ack_i), .int_o(int_o),
  .num_o(num_o), .vector_o(vector_o), .master_base_i(master_base_i),
  .slave_base_i(slave_base_i), .casc_q(casc_q), .master_irr(master_irr),
  .slave_irr(slave_irr), .master_ack(master_ack), .master_ack_line(master_ack_line),
  .slave_ack(slave_ack), .slave_ack_line(slave_ack_line)
);

// File: tb/pic_cascade_ack_bench.sv
`timescale 1ns/1ps
module pic_cascade_ack_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic [7:0]  mbase = 8'h23, sbase = 8'h7F;
  logic        ack = 1'b0, eoi = 1'b0;
  logic [3:0]  eoi_num = '0;
  logic        int_o;
  logic [3:0]  num_o;
  logic [7:0]  vector_o;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  pic_cascade_ack u_pic_cascade_ack (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .master_base_i(mbase),
    .slave_base_i(sbase), .ack_i(ack), .eoi_i(eoi), .eoi_num_i(eoi_num),
    .int_o(int_o), .num_o(num_o), .vector_o(vector_o)
  );

  // ---------------- reference model ----------------
  int m_irr, m_isr, m_last, s_irr, s_isr, s_last, casc, e_num, e_vec;

  function automatic int low8(input int v);
    for (int i = 0; i < 8; i++) if (((v >> i) & 1) == 1) return i;
    return 8;
  endfunction

  always @(posedge clk) begin : model
    int m_in, s_in, mw, sw, number, m_set, s_set, m_clr, s_clr;
    bit mok, sok;
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_last = 0; s_irr = 0; s_isr = 0; s_last = 0;
      casc = 0; e_num = 0; e_vec = 0;
    end else begin
      m_in = (int'(irq[7:0]) & 'hFB) | (casc << 2);
      s_in = int'(irq[15:8]);
      mw = low8(m_irr); mok = mw < low8(m_isr);
      sw = low8(s_irr); sok = sw < low8(s_isr);
      if (!mok) number = 7;
      else if (mw == 2) number = 8 + (sok ? sw : 7);
      else number = mw;
      m_set = 0; s_set = 0; m_clr = 0; s_clr = 0;
      if (ack) begin
        e_num = number;
        e_vec = ((number >= 8) ? (int'(sbase) & 'hF8) : (int'(mbase) & 'hF8)) + (number % 8);
        if (mok) m_set = 1 << mw;
        if (mok && mw == 2 && sok) s_set = 1 << sw;
      end
      if (eoi) begin
        if (eoi_num >= 8) begin s_clr = 1 << (eoi_num - 8); m_clr = 1 << 2; end
        else m_clr = 1 << eoi_num;
      end
      m_irr = (m_irr & ~m_set) | (m_in & ~m_last);
      s_irr = (s_irr & ~s_set) | (s_in & ~s_last);
      m_isr = (m_isr & ~m_clr) | m_set;
      s_isr = (s_isr & ~s_clr) | s_set;
      m_last = m_in; s_last = s_in;
      casc = (sok && casc == 0) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (int_o !== (low8(m_irr) < low8(m_isr)) || int'(num_o) != e_num || int'(vector_o) != e_vec) begin
        n_fail++;
        $display("FAIL model [%s] int/num/vec actual=%0b/%0d/%02h expected=%0b/%0d/%02h",
                 cur_req, int_o, num_o, vector_o, (low8(m_irr) < low8(m_isr)), e_num, e_vec);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    #6;
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic do_eoi(input int n);
    eoi = 1'b1; eoi_num = 4'(n); step(1); eoi = 1'b0;
  endtask

  // ---------------- stimulus ----------------
  bit done = 0;

  initial begin
    step(3);
    chk("R1", "int_o in reset", int'(int_o), 0);
    chk("R1", "num_o in reset", int'(num_o), 0);
    chk("R1", "vector_o in reset", int'(vector_o), 0);
    rst_n = 1'b1;

    cur_req = "R2"; irq[5] = 1'b1; step(1);
    chk("R2", "int_o after edge", int'(int_o), 1);
    cur_req = "R5"; do_ack();
    chk("R5", "num_o line 5", int'(num_o), 5);
    chk("R6", "vector master base ignores low bits", int'(vector_o), 'h25);
    step(1);
    chk("R7", "int_o after master ack", int'(int_o), 0);
    do_eoi(5); step(2);
    chk("R2", "held level gives no new request", int'(int_o), 0);
    irq[5] = 1'b0;

    cur_req = "R3"; irq[6] = 1'b1; irq[3] = 1'b1; step(1);
    do_ack();
    chk("R3", "lowest line wins", int'(num_o), 3);
    irq[1] = 1'b1; step(1);
    chk("R3", "higher line nests over in-service", int'(int_o), 1);
    do_ack();
    chk("R3", "nested number", int'(num_o), 1);
    step(1);
    chk("R3", "line 6 blocked by service", int'(int_o), 0);
    do_eoi(1); #1;
    chk("R3", "line 6 still blocked by line 3", int'(int_o), 0);
    step(0); do_eoi(3); #1;
    chk("R9", "master EOI releases line 6", int'(int_o), 1);
    step(0); do_ack();
    chk("R3", "blocked line served last", int'(num_o), 6);
    do_eoi(6); irq[6] = 1'b0; irq[3] = 1'b0; irq[1] = 1'b0;

    cur_req = "R8"; step(1); do_ack();
    chk("R8", "spurious master number", int'(num_o), 7);
    chk("R8", "spurious master vector", int'(vector_o), 'h27);

    cur_req = "R10"; irq[2] = 1'b1; step(4);
    chk("R10", "input 2 ignored", int'(int_o), 0);
    irq[2] = 1'b0;

    cur_req = "R4"; step(1); irq[11] = 1'b1; step(2);
    chk("R4", "no interrupt before cascade reaches master", int'(int_o), 0);
    step(0); step(1);
    chk("R4", "interrupt after cascade pulse", int'(int_o), 1);
    cur_req = "R5"; step(0); do_ack();
    chk("R5", "slave number", int'(num_o), 11);
    chk("R6", "slave vector", int'(vector_o), 'h7B);
    step(1);
    chk("R7", "both cores in service", int'(int_o), 0);
    cur_req = "R9"; step(0); do_eoi(11); #1;
    chk("R9", "slave EOI frees master line 2", int'(int_o), 1);
    cur_req = "R8"; step(0); do_ack();
    chk("R8", "stale cascade gives spurious slave number", int'(num_o), 15);
    chk("R8", "spurious slave vector", int'(vector_o), 'h7F);
    do_eoi(15); irq[11] = 1'b0; step(3);

    cur_req = "R3"; irq[14] = 1'b1; irq[0] = 1'b1; step(1);
    do_ack();
    chk("R3", "master line 0 beats cascade", int'(num_o), 0);
    do_eoi(0); step(2);
    do_ack();
    chk("R5", "slave line 6 after master served", int'(num_o), 14);
    do_eoi(14); irq[14] = 1'b0; irq[0] = 1'b0;
    step(6);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog [%s] actual=running expected=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule